// File: doc/BRIEF.md
# Decimal Seconds Counter with Prescaled Tick

This block counts elapsed seconds as two BCD digits running from 00 up to 59 and then wrapping back to 00. It runs from a single fast system clock. An internal prescaler divides that clock down to a one-cycle enable pulse, and each pulse advances the count by one.

The low digit steps through 0 to 9. The high digit steps through 0 to 5 and moves only when the low digit wraps. Every register sits on the system clock and uses the tick as a clock enable, so the design has no derived clock nets. The division ratio is a parameter. Its default gives one tick per second from a 100 MHz clock, and a bench can set a small value to keep runs short.

Top module: `sec_count`

## Requirements
- R1: A synchronous active-high reset sets both digits to 0 and restarts the prescaler, so the first tick after reset comes on the DIV-th rising edge that has reset low.
- R2: The tick output is high for exactly one clock in every DIV clocks and is never high on two consecutive clocks.
- R3: The low digit (`units`, BCD in bits 3:0) advances by one on each tick and holds its value on every clock without a tick.
- R4: On a tick the low digit goes from 9 to 0; it never holds a value above 9.
- R5: The high digit (`tens`, BCD) advances by one only on a tick that finds the low digit at 9; otherwise it holds.
- R6: The high digit never exceeds 5, and on a tick at a count of 59 both digits become 0 on the same edge.
- R7: The parameter DIV (default 100,000,000, minimum 2) sets the ratio between the clock and the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | output | 1 | One-cycle enable, once per DIV clocks |
| units | output | 4 | Low BCD digit, 0 to 9 |
| tens | output | 4 | High BCD digit, 0 to 5 |

## Verification
On every cycle, the assertions check the following:
- Both digits stay within their BCD ranges.
- The tick never lasts two clocks.
- The digits change only on a tick.
- The low digit steps or wraps correctly.
- The high digit moves only when the low digit wraps.
- The 59-to-00 wrap happens in one step.

Only the bench scenarios can show the exact tick spacing of DIV clocks from reset, the full sequence of sixty values across a complete minute, and a mid-count reset restarting the prescaler phase.

// File: rtl/sec_count.sv
module sec_count #(
  parameter int unsigned DIV = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  output logic       tick,
  output logic [3:0] units,
  output logic [3:0] tens
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;
  logic          u_wrap;

  assign tick   = (pre == LAST);
  assign u_wrap = tick && (units == 4'd9);

  always_ff @(posedge clk) begin
    if (rst || tick) pre <= '0;
    else             pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         units <= 4'd0;
    else if (u_wrap) units <= 4'd0;
    else if (tick)   units <= units + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)                           tens <= 4'd0;
    else if (u_wrap && tens == 4'd5)   tens <= 4'd0;
    else if (u_wrap)                   tens <= tens + 4'd1;
  end

  p_units_range_r4: assert property (@(posedge clk) disable iff (rst) units <= 4'd9);
  p_tens_range_r6: assert property (@(posedge clk) disable iff (rst) tens <= 4'd5);
  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
  p_units_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(units));
  p_units_step_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && units != 4'd9) |=> units == $past(units) + 4'd1);
  p_units_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && units == 4'd9) |=> units == 4'd0);
  p_tens_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(tick && units == 4'd9) |=> $stable(tens));
  p_full_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && units == 4'd9 && tens == 4'd5) |=> (units == 4'd0 && tens == 4'd0));
endmodule

// File: tb/test_sec_count.sv
module test_sec_count;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick;
  logic [3:0] units, tens;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  sec_count #(.DIV(DIV)) i_sec_count (.clk(clk), .rst(rst), .tick(tick), .units(units), .tens(tens));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    rst = 1'b1; step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset;
    do_reset();
    check(units == 0, "R1 units", units, 0);
    check(tens == 0, "R1 tens", tens, 0);
    check(tick == 0, "R1 tick", tick, 0);
  endtask

  task automatic t_tick_spacing;
    int ticks = 0;
    int first = -1;
    do_reset();
    for (int c = 1; c <= 4*DIV; c++) begin
      if (tick) begin
        ticks++;
        if (first < 0) first = c;
      end
      step();
    end
    check(first == DIV, "R1 R7 first tick cycle", first, DIV);
    check(ticks == 4, "R2 R7 tick count", ticks, 4);
  endtask

  task automatic t_hold;
    do_reset();
    for (int c = 0; c < DIV - 1; c++) step();
    check(units == 0, "R3 units hold without tick", units, 0);
    step();
    check(units == 1, "R3 units step on tick", units, 1);
  endtask

  task automatic t_minute;
    int exp_u = 0, exp_t = 0;
    int bad = 0;
    do_reset();
    for (int s = 1; s <= 61; s++) begin
      for (int c = 0; c < DIV; c++) step();
      exp_u++;
      if (exp_u == 10) begin exp_u = 0; exp_t++; end
      if (exp_t == 6) exp_t = 0;
      if (units != exp_u || tens != exp_t) begin
        bad++;
        check(0, "R3 R4 R5 sequence", tens*10+units, exp_t*10+exp_u);
      end
      if (s == 10) check(units == 0 && tens == 1, "R4 R5 9->10", tens*10+units, 10);
      if (s == 59) check(units == 9 && tens == 5, "R6 reach 59", tens*10+units, 59);
      if (s == 60) check(units == 0 && tens == 0, "R6 59->00", tens*10+units, 0);
    end
    check(bad == 0, "R5 R6 minute errors", bad, 0);
  endtask

  task automatic t_mid_reset;
    do_reset();
    for (int c = 0; c < 3*DIV + 2; c++) step();
    check(units == 3, "R3 count before reset", units, 3);
    do_reset();
    check(units == 0 && tens == 0, "R1 mid reset clears", units, 0);
    for (int c = 0; c < DIV - 1; c++) step();
    check(units == 0, "R1 prescaler restarted", units, 0);
    step();
    check(units == 1, "R1 first tick after mid reset", units, 1);
  endtask

  initial begin
    t_reset();
    t_tick_spacing();
    t_hold();
    t_minute();
    t_mid_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule